// File: doc/BRIEF.md
# Prescaled Countdown Timer with Interrupt Flag

This block is a single 32-bit down-counter that a processor programs through a small word-wide register window. Software writes a start value and a control word. The counter then steps down once every P+1 clock cycles, where P is a prescale value held in the control word. When the counter reaches zero, the block raises a sticky status flag. With auto-reload on, the counter refills from the stored reload value and keeps running. With auto-reload off, it stops at zero.

The interrupt line is a level output that follows the status flag. Software clears the flag by writing a one to the status bit. Writing either the reload register or the counter register while the timer runs restarts the countdown from the written value, and the prescale phase starts again. Enabling the timer while the counter is zero and auto-reload is set first fills the counter from the reload register.

Accesses use a plain valid/write/address/data port. Writes take effect at the clock edge where valid is high. Read data is registered and appears one cycle after the read request.

Top module: `cdt_timer`

## Requirements
- R1: After synchronous reset, the reload value, the counter, the control word and the status flag are all zero, `irq` is low, and every register reads as zero.
- R2: Only address bits [4:0] select a register, so the window repeats every 32 bytes. The offsets are 0x00 reload, 0x04 counter, 0x08 control and 0x0C status. Any other offset reads as zero, and a write to it changes nothing.
- R3: A write to 0x00 sets both the reload value and the counter to the written data. A write to 0x04 sets only the counter.
- R4: The control word has enable at bit 0, auto-reload at bit 1 and the prescale value P at bits [15:8]. All other control bits read as zero. While the timer is enabled and the counter is nonzero, the counter decrements once every P+1 cycles, and the first decrement comes exactly P+1 cycles after counting starts. While the timer is disabled, the counter holds its value.
- R5: A write to 0x00 or 0x04 while enabled restarts the countdown from the new value with the prescale phase cleared. A count of C then expires C*(P+1) cycles after the write edge.
- R6: When a control write changes enable from 0 to 1 with auto-reload set in the written value and the counter at zero, the counter is first filled from the reload value and then counts.
- R7: When a decrement takes the counter to zero, the status flag is set. With auto-reload set, the counter refills from the reload value and keeps counting. Otherwise it stays at zero.
- R8: Writing 0x0C with bit 0 set clears the status flag, and writing it with bit 0 clear leaves the flag unchanged. If an expiry and a clear fall in the same cycle, the flag ends up set.
- R9: `irq` is a level that equals the status flag. It changes only on an expiry or a clear.
- R10: A read of 0x04 returns zero when enable is clear or the counter is zero. Otherwise it returns the remaining count.
- R11: With the timer enabled and the counter at zero, no expiry ever occurs, so `irq` cannot rise until a nonzero count is loaded.
- R12: Read data for a request at clock edge N is presented on `bus_rdata` after edge N and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [4:0] decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
The bench aims at the cycle where an expiry and a status clear coincide; a design that let the clear win would lose an interrupt without any trace. It enables the timer with a zero counter and auto-reload set; a design that skipped the fill would sit silent forever. It rewrites the counter partway through a prescale period and times the expiry from that write; a design that kept the old prescale phase would fire a few cycles early. It also reads the counter while the timer is disabled, and reads offsets outside the map; a wrong design would return a stale count or garbage instead of zero.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Width of the decoded register window (32 bytes).
  localparam int WIN_W = 5;

  // Register offsets within the window.
  localparam logic [WIN_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [WIN_W-1:0] OFS_COUNT  = 5'h04;
  localparam logic [WIN_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [WIN_W-1:0] OFS_FLAG   = 5'h0C;

  // Control word bit positions.
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_AUTO_BIT  = 1;
  localparam int CTL_PRESC_LSB = 8;

  // Status word bit position.
  localparam int FLAG_BIT = 0;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [WIN_W-1:0]  win_ofs,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] count,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] reload_val,
  output logic              ctrl_en,
  output logic              ctrl_auto,
  output logic [PRESC_W-1:0] presc,
  output logic              wr_cnt,
  output logic              en_rise,
  output logic              rise_fill,
  output logic              flag
);
  logic wr_any, rd_any;
  logic wr_reload, wr_ctrl, wr_flag;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] count_view;
  logic [DATA_W-1:0] flag_word;
  logic [DATA_W-1:0] rd_mux;

  assign wr_any    = bus_valid && bus_write;
  assign rd_any    = bus_valid && !bus_write;
  assign wr_reload = wr_any && (win_ofs == OFS_RELOAD);
  assign wr_cnt    = wr_any && ((win_ofs == OFS_RELOAD) || (win_ofs == OFS_COUNT));
  assign wr_ctrl   = wr_any && (win_ofs == OFS_CTRL);
  assign wr_flag   = wr_any && (win_ofs == OFS_FLAG);
  assign en_rise   = wr_ctrl && !ctrl_en && bus_wdata[CTL_EN_BIT];
  assign rise_fill = en_rise && bus_wdata[CTL_AUTO_BIT];

  // Stored registers
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_val <= '0;
      ctrl_en    <= 1'b0;
      ctrl_auto  <= 1'b0;
      presc      <= '0;
    end else begin
      if (wr_reload) reload_val <= bus_wdata;
      if (wr_ctrl) begin
        ctrl_en   <= bus_wdata[CTL_EN_BIT];
        ctrl_auto <= bus_wdata[CTL_AUTO_BIT];
        presc     <= bus_wdata[CTL_PRESC_LSB +: PRESC_W];
      end
    end
  end

  // Sticky status flag: an expiry outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                                  flag <= 1'b0;
    else if (expire)                          flag <= 1'b1;
    else if (wr_flag && bus_wdata[FLAG_BIT])  flag <= 1'b0;
  end

  // Readback views
  always_comb begin
    ctrl_word                            = '0;
    ctrl_word[CTL_EN_BIT]                = ctrl_en;
    ctrl_word[CTL_AUTO_BIT]              = ctrl_auto;
    ctrl_word[CTL_PRESC_LSB +: PRESC_W]  = presc;
    flag_word                            = '0;
    flag_word[FLAG_BIT]                  = flag;
    count_view = (ctrl_en && (count != '0)) ? count : '0;
    case (win_ofs)
      OFS_RELOAD: rd_mux = reload_val;
      OFS_COUNT:  rd_mux = count_view;
      OFS_CTRL:   rd_mux = ctrl_word;
      OFS_FLAG:   rd_mux = flag_word;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_any) rdata <= rd_mux;
  end
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] phase;

  // A step is due once the phase has covered P+1 cycles.
  assign tick = run && (phase >= presc);

  always_ff @(posedge clk) begin
    if (rst || restart) phase <= '0;
    else if (run)       phase <= tick ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_fill,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              auto,
  input  logic              tick,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic at_one;
  assign at_one = (count == ONE);
  // A bus write that lands on a step edge takes precedence and suppresses the expiry.
  assign expire = tick && at_one && !wr_cnt;

  always_ff @(posedge clk) begin
    if (rst)                             count <= '0;
    else if (wr_cnt)                     count <= wdata;
    else if (rise_fill && count == '0)   count <= reload_val;
    else if (tick) begin
      if (at_one) count <= auto ? reload_val : '0;
      else        count <= count - ONE;
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int PRESC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [WIN_W-1:0]   win_ofs;
  logic               addr_unused;
  logic [DATA_W-1:0]  count_q;
  logic [DATA_W-1:0]  reload_val;
  logic               ctrl_en, ctrl_auto;
  logic [PRESC_W-1:0] presc;
  logic               wr_cnt, en_rise, rise_fill;
  logic               flag, expire, presc_tick, run;

  // Upper address bits do not take part in decoding: the window aliases.
  assign win_ofs     = bus_addr[WIN_W-1:0];
  assign addr_unused = ^bus_addr[ADDR_W-1:WIN_W];
  assign run         = ctrl_en && (count_q != '0);

  cdt_regs #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .win_ofs(win_ofs), .bus_wdata(bus_wdata),
    .count(count_q), .expire(expire),
    .rdata(bus_rdata), .reload_val(reload_val),
    .ctrl_en(ctrl_en), .ctrl_auto(ctrl_auto), .presc(presc),
    .wr_cnt(wr_cnt), .en_rise(en_rise), .rise_fill(rise_fill),
    .flag(flag)
  );

  cdt_prescale #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst),
    .restart(wr_cnt || en_rise), .run(run),
    .presc(presc), .tick(presc_tick)
  );

  cdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst),
    .wr_cnt(wr_cnt), .wdata(bus_wdata),
    .rise_fill(rise_fill), .reload_val(reload_val),
    .auto(ctrl_auto), .tick(presc_tick),
    .count(count_q), .expire(expire)
  );

  assign irq = flag;
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [4:0]        ofs,
  input logic              clr_bit,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] count,
  input logic              tick,
  input logic              expire,
  input logic              ctrl_en,
  input logic              ctrl_auto,
  input logic              wr_cnt,
  input logic              en_rise
);
  logic rd_req, clr_req, unmapped;
  assign rd_req   = bus_valid && !bus_write;
  assign clr_req  = bus_valid && bus_write && (ofs == 5'h0C) && clr_bit;
  assign unmapped = (ofs != 5'h00) && (ofs != 5'h04) && (ofs != 5'h08) && (ofs != 5'h0C);

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && unmapped) |=> (bus_rdata == '0));

  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_cnt && count > 1) |=> (count == $past(count) - 1));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !wr_cnt && !en_rise) |=> $stable(count));

  p_expiry_sets_r7: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq);

  p_stop_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctrl_auto) |=> (count == '0));

  p_irq_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (!expire && !clr_req) |=> $stable(irq));

  p_count_hidden_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_req && ofs == 5'h04 && !ctrl_en) |=> (bus_rdata == '0));

  p_rise_from_one_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(count) == 1));
endmodule

bind cdt_timer cdt_checker #(.DATA_W(DATA_W)) u_cdt_chk (
  .clk(clk), .rst(rst),
  .bus_valid(bus_valid), .bus_write(bus_write),
  .ofs(bus_addr[4:0]), .clr_bit(bus_wdata[0]),
  .bus_rdata(bus_rdata), .irq(irq),
  .count(count_q), .tick(presc_tick), .expire(expire),
  .ctrl_en(ctrl_en), .ctrl_auto(ctrl_auto),
  .wr_cnt(wr_cnt), .en_rise(en_rise)
);

// File: tb/tb_cdt_timer.sv
`timescale 1ns/1ps
module tb_cdt_timer;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int WATCHDOG = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #10 clk = ~clk;

  cdt_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Driver tasks: called at a falling edge, return at the next falling edge.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor (R12): data for a read taken at an edge is compared at the next falling edge.
  always @(posedge clk) begin
    if (!rst && bus_valid && !bus_write) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12: unexpected read data %h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    rd(12'h000, 0, "R1 reload");
    rd(12'h004, 0, "R1 count");
    rd(12'h008, 0, "R1 ctrl");
    rd(12'h00C, 0, "R1 flag");

    // R3 reload write vs counter write; R10 hidden while disabled
    wr(12'h000, 5);
    wr(12'h004, 3);
    rd(12'h000, 5, "R3 reload kept after counter write");
    rd(12'h004, 0, "R10 count hidden while disabled");

    // R4 one-shot, P=2, count 3: expiry 9 cycles after enable
    wr(12'h008, 32'h0000_0201);
    rd(12'h004, 3, "R4 count at start");
    wait_cyc(7);
    chk("R4 irq before expiry", {31'b0, irq}, 0);
    wait_cyc(1);
    chk("R7 irq at expiry", {31'b0, irq}, 1);
    rd(12'h004, 0, "R7 one-shot stops at zero");
    rd(12'h00C, 1, "R7 flag set");
    wr(12'h00C, 0);
    rd(12'h00C, 1, "R8 zero write keeps flag");
    wr(12'h00C, 1);
    chk("R9 irq follows clear", {31'b0, irq}, 0);
    rd(12'h00C, 0, "R8 flag cleared");

    // R6 enable with zero counter and auto-reload, P=0
    wr(12'h008, 0);
    wr(12'h000, 4);
    wr(12'h004, 0);
    wr(12'h008, 32'h0000_0003);
    rd(12'h004, 4, "R6 filled from reload");
    wait_cyc(2);
    chk("R6 irq before expiry", {31'b0, irq}, 0);
    wait_cyc(1);
    chk("R7 periodic first expiry", {31'b0, irq}, 1);
    rd(12'h004, 4, "R7 refilled after expiry");
    wr(12'h00C, 1);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    wait_cyc(2);
    chk("R7 periodic second expiry", {31'b0, irq}, 1);
    wait_cyc(3);
    wr(12'h00C, 1);  // lands on the third expiry edge
    chk("R8 expiry wins over clear", {31'b0, irq}, 1);

    // R5 restart while running, P=3
    wr(12'h008, 0);
    wr(12'h00C, 1);
    wr(12'h004, 10);
    wr(12'h008, 32'h0000_0301);
    wait_cyc(2);
    wr(12'h004, 2);
    rd(12'h004, 2, "R5 restart value");
    wait_cyc(3);
    rd(12'h004, 1, "R4 first step after P+1");
    wait_cyc(2);
    chk("R5 irq before expiry", {31'b0, irq}, 0);
    wait_cyc(1);
    chk("R5 irq at restarted expiry", {31'b0, irq}, 1);
    wr(12'h00C, 1);
    wr(12'h000, 1);
    wait_cyc(3);
    chk("R3 reload write restarts, early", {31'b0, irq}, 0);
    wait_cyc(1);
    chk("R3 reload write restarts, expiry", {31'b0, irq}, 1);
    rd(12'h000, 1, "R3 reload value");

    // R11 enabled with zero count never fires
    wr(12'h008, 0);
    wr(12'h00C, 1);
    wr(12'h004, 0);
    wr(12'h008, 32'h0000_0001);
    wait_cyc(20);
    chk("R11 no expiry from zero", {31'b0, irq}, 0);
    rd(12'h004, 0, "R11 count stays zero");

    // R2 decode, aliasing and unmapped offsets; R4 control layout
    rd(12'h010, 0, "R2 unmapped 0x10");
    rd(12'h01C, 0, "R2 unmapped 0x1C");
    wr(12'h014, 32'h0000_FFFF);
    rd(12'h000, 1, "R2 unmapped write ignored");
    rd(12'h020, 1, "R2 alias at 0x20");
    rd(12'hFE0, 1, "R2 alias at 0xFE0");
    wr(12'h008, 32'h0000_AB02);
    rd(12'h008, 32'h0000_AB02, "R4 control readback");
    wr(12'h008, 32'hFFFF_00FC);
    rd(12'h008, 0, "R4 unused control bits read zero");

    wait_cyc(3);
    chk("R12 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule